// File: doc/BRIEF.md
# Software DMA Request Register Unit

This block lets software post DMA transfer requests on a set of request lines through a small word-addressed register bus. It holds two independent sets of software request flags, one for burst transfers and one for single transfers. A write of 1 to a flag raises that line's request. Writing 0 leaves the flag as it is. The DMA engine clears a flag through a completion strobe of the matching type once the transfer for that line has finished.

The request vectors presented to the DMA engine are the bitwise OR of the software flags and the peripheral request inputs of the same type. Reading either request register returns this merged view, so software sees every outstanding request. A third read-only word reports which DMA channels are enabled. Its value is taken from a status input.

Top module: `swdma_req_unit`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, every software burst flag and every software single flag is cleared at that edge.
- R2: A write to byte offset 0x20 sets the software burst flag of line i for each bit i in 15:0 of the write data that is 1. Data bits that are 0 leave their flags unchanged.
- R3: A write to byte offset 0x24 sets the software single flag of line i for each bit i in 15:0 of the write data that is 1. Data bits that are 0 leave their flags unchanged.
- R4: A software flag stays set until a completion strobe of its own type arrives for its line. Bit i of `burst_done_i` clears only burst flag i, and bit i of `single_done_i` clears only single flag i.
- R5: When a write sets a flag in the same cycle that a completion strobe clears it, the flag ends up set.
- R6: `burst_req_o` equals the software burst flags OR `periph_burst_i`, and `single_req_o` equals the software single flags OR `periph_single_i`. Both outputs are combinational from the flags and the inputs.
- R7: A read at offset 0x20 or 0x24 returns the merged burst or single request vector in bits 15:0, with bits 31:16 reading as zero. `reg_rdata` is combinational from `reg_addr`.
- R8: A read at offset 0x1C returns `chan_en_i` in bits 7:0, with bits 31:8 reading as zero. Writes to 0x1C change no flag.
- R9: Write data bits 31:16 have no effect. Writes to any offset other than 0x20 and 0x24 change no flag. Reads at any other offset return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_addr | input | 8 | Byte address of the register access |
| reg_we | input | 1 | Write strobe for one cycle |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, combinational from `reg_addr` |
| periph_burst_i | input | 16 | Peripheral burst request lines |
| periph_single_i | input | 16 | Peripheral single request lines |
| burst_done_i | input | 16 | Per-line completion strobes for burst transfers |
| single_done_i | input | 16 | Per-line completion strobes for single transfers |
| chan_en_i | input | 8 | Enabled state of each DMA channel |
| burst_req_o | output | 16 | Merged burst request vector |
| single_req_o | output | 16 | Merged single request vector |

## Verification
Every cycle, the assertions check four things. Reset empties both flag sets. A flag that is set and not struck by its own completion strobe stays set. No flag appears without a write. A write always overrides a completion strobe in the same cycle. They also check on every cycle that the merged outputs cover the peripheral lines and that the upper bits of the read data are zero. Some behaviour needs the scenarios to show it. Burst strobes must leave single flags alone, and the reverse. Zero data and upper data bits must be ignored. Writes to the status word and to unmapped offsets must change nothing. The read data must carry the right merged value at each offset.

// File: rtl/swdma_pkg.sv
// Package: shared sizes and register offsets of the software DMA request unit.
// Assumes word-aligned byte addresses on the register bus.
package swdma_pkg;
    localparam int unsigned LINES   = 16;
    localparam int unsigned CHANS   = 8;
    localparam int unsigned ADDR_W  = 8;
    localparam int unsigned DATA_W  = 32;
    localparam int unsigned WORD_LSB = 2;

    localparam logic [ADDR_W-1:0] OFS_CHAN_EN = 8'h1C;
    localparam logic [ADDR_W-1:0] OFS_BURST   = 8'h20;
    localparam logic [ADDR_W-1:0] OFS_SINGLE  = 8'h24;

    typedef enum logic [1:0] {
        SEL_NONE   = 2'd0,
        SEL_CHAN   = 2'd1,
        SEL_BURST  = 2'd2,
        SEL_SINGLE = 2'd3
    } reg_sel_e;

    // Word-level address compare, ignoring the byte lane bits.
    function automatic logic word_hit(input logic [ADDR_W-1:0] a,
                                      input logic [ADDR_W-1:0] ofs);
        return a[ADDR_W-1:WORD_LSB] == ofs[ADDR_W-1:WORD_LSB];
    endfunction
endpackage

// File: rtl/swdma_decode.sv
// Module: swdma_decode
// Decodes a register address into a register select.
// Assumes the offsets in swdma_pkg are distinct words.
module swdma_decode
    import swdma_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    output reg_sel_e          sel
);
    // Map address to register select; unmapped gives SEL_NONE.
    always_comb begin
        if (word_hit(addr, OFS_BURST))        sel = SEL_BURST;
        else if (word_hit(addr, OFS_SINGLE))  sel = SEL_SINGLE;
        else if (word_hit(addr, OFS_CHAN_EN)) sel = SEL_CHAN;
        else                                  sel = SEL_NONE;
    end
endmodule

// File: rtl/swdma_flag_bank.sv
// Module: swdma_flag_bank
// One set of software request flags: write-one-to-set, cleared per line by
// a completion strobe. A set in the same cycle as a clear wins.
// Assumes set_v and done_v are synchronous to clk.
module swdma_flag_bank #(
    parameter int unsigned N = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_v,
    input  logic [N-1:0] done_v,
    output logic [N-1:0] req_q
);
    // Flag update: clear completed lines, then apply new sets.
    always_ff @(posedge clk) begin
        if (!rst_n) req_q <= '0;
        else        req_q <= (req_q & ~done_v) | set_v;
    end

    // R1
    reset_clears_chk: assert property (@(posedge clk) !rst_n |=> (req_q == '0));

    // R4
    flag_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((req_q & $past(req_q & ~done_v)) == $past(req_q & ~done_v)));

    // R4
    no_spurious_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((req_q & ~$past(req_q | set_v)) == '0));

    // R5
    set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|(set_v & done_v)) |=> ((req_q & $past(set_v)) == $past(set_v)));
endmodule

// File: rtl/swdma_read_mux.sv
// Module: swdma_read_mux
// Selects the read word and zero-extends it to the bus width.
// Assumes LINES and CHANS are both no larger than the bus width.
module swdma_read_mux
    import swdma_pkg::*;
(
    input  reg_sel_e          sel,
    input  logic [LINES-1:0]  burst_v,
    input  logic [LINES-1:0]  single_v,
    input  logic [CHANS-1:0]  chan_v,
    output logic [DATA_W-1:0] rdata
);
    // Zero-extended read value for the selected register.
    always_comb begin
        rdata = '0;
        unique case (sel)
            SEL_BURST:  rdata[LINES-1:0] = burst_v;
            SEL_SINGLE: rdata[LINES-1:0] = single_v;
            SEL_CHAN:   rdata[CHANS-1:0] = chan_v;
            default:    rdata = '0;
        endcase
    end
endmodule

// File: rtl/swdma_req_unit.sv
// Module: swdma_req_unit (top)
// Software-posted DMA burst and single requests, merged with peripheral
// requests; also a read-only channel-enable status word.
// Assumes a single-cycle write strobe and combinational reads.
module swdma_req_unit
    import swdma_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [7:0]        reg_addr,
    input  logic              reg_we,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic [15:0]       periph_burst_i,
    input  logic [15:0]       periph_single_i,
    input  logic [15:0]       burst_done_i,
    input  logic [15:0]       single_done_i,
    input  logic [7:0]        chan_en_i,
    output logic [15:0]       burst_req_o,
    output logic [15:0]       single_req_o
);
    reg_sel_e         sel;
    logic [LINES-1:0] set_burst, set_single;
    logic [LINES-1:0] sw_burst, sw_single;

    swdma_decode dec_i (.addr(reg_addr), .sel(sel));

    // Per-bank set masks from a write; upper data bits are dropped.
    always_comb begin
        set_burst  = (reg_we && sel == SEL_BURST)  ? reg_wdata[LINES-1:0] : '0;
        set_single = (reg_we && sel == SEL_SINGLE) ? reg_wdata[LINES-1:0] : '0;
    end

    swdma_flag_bank #(.N(LINES)) burst_bank_i (
        .clk(clk), .rst_n(rst_n), .set_v(set_burst),
        .done_v(burst_done_i), .req_q(sw_burst));

    swdma_flag_bank #(.N(LINES)) single_bank_i (
        .clk(clk), .rst_n(rst_n), .set_v(set_single),
        .done_v(single_done_i), .req_q(sw_single));

    // Merge software flags with peripheral lines.
    always_comb begin
        burst_req_o  = sw_burst  | periph_burst_i;
        single_req_o = sw_single | periph_single_i;
    end

    swdma_read_mux rd_i (
        .sel(sel), .burst_v(burst_req_o), .single_v(single_req_o),
        .chan_v(chan_en_i), .rdata(reg_rdata));

    // R6
    merge_covers_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((burst_req_o & periph_burst_i) == periph_burst_i) &&
        ((single_req_o & periph_single_i) == periph_single_i));

    // R7
    rdata_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rdata[31:LINES] == '0);
endmodule

// File: tb/swdma_req_unit_tb.sv
// Bench for swdma_req_unit: a vector table walked by one loop, then directed
// tests for reset, reads and corner cases.
module swdma_req_unit_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  reg_addr = '0;
    logic        reg_we = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [15:0] periph_burst_i = '0, periph_single_i = '0;
    logic [15:0] burst_done_i = '0, single_done_i = '0;
    logic [7:0]  chan_en_i = '0;
    logic [15:0] burst_req_o, single_req_o;

    int errors = 0;
    int checks = 0;

    always #10 clk = ~clk;

    swdma_req_unit dut_i (.*);

    typedef struct packed {
        logic [7:0]  addr;
        logic        we;
        logic [31:0] wdata;
        logic [15:0] pb, ps, bd, sd;
        logic [15:0] exp_b, exp_s;
    } vec_t;

    localparam int NV = 8;
    localparam vec_t TBL [NV] = '{
        // R2 R9: burst write, upper data ignored
        '{8'h20, 1'b1, 32'hFFFF_0005, 16'h0, 16'h0, 16'h0, 16'h0, 16'h0005, 16'h0000},
        // R3: single write
        '{8'h24, 1'b1, 32'h0000_8001, 16'h0, 16'h0, 16'h0, 16'h0, 16'h0005, 16'h8001},
        // R2 R6: zero write no effect, peripheral burst merged
        '{8'h20, 1'b1, 32'h0000_0000, 16'h0100, 16'h0, 16'h0, 16'h0, 16'h0105, 16'h8001},
        // R4: burst done on line 0 leaves single line 0
        '{8'h00, 1'b0, 32'h0, 16'h0, 16'h0, 16'h0001, 16'h0, 16'h0004, 16'h8001},
        // R4: single done on line 15
        '{8'h00, 1'b0, 32'h0, 16'h0, 16'h0, 16'h0, 16'h8000, 16'h0004, 16'h0001},
        // R5: set line 1 while done hits lines 1 and 2
        '{8'h20, 1'b1, 32'h0000_0002, 16'h0, 16'h0, 16'h0006, 16'h0, 16'h0002, 16'h0001},
        // R8 R6: write to status word ignored, peripheral single merged
        '{8'h1C, 1'b1, 32'hFFFF_FFFF, 16'h0, 16'h0040, 16'h0, 16'h0, 16'h0002, 16'h0041},
        // R9: write to unmapped offset ignored
        '{8'h28, 1'b1, 32'hFFFF_FFFF, 16'h0, 16'h0, 16'h0, 16'h0, 16'h0002, 16'h0001}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic idle();
        @(negedge clk);
        reg_we = 1'b0; burst_done_i = '0; single_done_i = '0;
        periph_burst_i = '0; periph_single_i = '0;
    endtask

    initial begin
        // Watchdog
        #2_000_000;
        errors++; checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        // R1: state after reset
        #1;
        check("R1", {burst_req_o, single_req_o}, 32'h0);
        reg_addr = 8'h20; #1;
        check("R7", reg_rdata, 32'h0);

        // Vector table
        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            reg_addr = TBL[i].addr; reg_we = TBL[i].we; reg_wdata = TBL[i].wdata;
            periph_burst_i = TBL[i].pb; periph_single_i = TBL[i].ps;
            burst_done_i = TBL[i].bd; single_done_i = TBL[i].sd;
            @(posedge clk); #2;
            check($sformatf("R2-table%0d burst", i), {16'h0, burst_req_o}, {16'h0, TBL[i].exp_b});
            check($sformatf("R3-table%0d single", i), {16'h0, single_req_o}, {16'h0, TBL[i].exp_s});
        end
        idle();
        // state now: sw burst 0002, sw single 0001

        // R7: read merged burst and single values
        periph_burst_i = 16'h1000; reg_addr = 8'h20; #1;
        check("R7 burst read", reg_rdata, 32'h0000_1002);
        periph_single_i = 16'h0200; reg_addr = 8'h24; #1;
        check("R7 single read", reg_rdata, 32'h0000_0201);

        // R8: status word read
        chan_en_i = 8'hA5; reg_addr = 8'h1C; #1;
        check("R8 chan read", reg_rdata, 32'h0000_00A5);

        // R9: unmapped read
        reg_addr = 8'h30; #1;
        check("R9 unmapped read", reg_rdata, 32'h0);
        idle();

        // R4: flags hold across idle cycles
        repeat (4) @(posedge clk);
        #2;
        check("R4 hold", {burst_req_o, single_req_o}, 32'h0002_0001);

        // R1: reset mid-operation clears flags
        @(negedge clk); rst_n = 1'b0;
        @(posedge clk); #2;
        check("R1 mid reset", {burst_req_o, single_req_o}, 32'h0);
        @(negedge clk); rst_n = 1'b1;

        // R5: single set wins over single done
        @(negedge clk);
        reg_addr = 8'h24; reg_we = 1'b1; reg_wdata = 32'h0000_0010; single_done_i = 16'h0010;
        @(posedge clk); #2;
        check("R5 single", {16'h0, single_req_o}, 32'h0000_0010);
        idle();

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule